// File: doc/BRIEF.md
# Strip Hit Serializer and Deserializer with Strobe Framing

This block moves one 16-bit strip hit vector per sample period across four data lanes that run at the system clock rate, four times the sample rate. The transmit half folds a pixel hit matrix into one bit per column by OR-ing every row of that column. It then sends the column vector as four 4-bit beats on consecutive system clocks, lowest beat first. A strobe line rises on the first beat that carries data and stays high while the acquisition window stays open. The receive half takes its frame phase from the rising edge of that strobe, rebuilds the 16-bit vector and hands it to the coincidence logic that follows.

The hit matrix enters through a valid/ready handshake. The transmitter raises ready only while the window is open and it sits at a frame boundary, which is either before its first frame or after the fourth beat of a frame. A producer that is not valid at a boundary of a running link does not stall the lanes: an all-zero frame goes out in its place, because the line rate is fixed. The rebuilt vector leaves with a one-cycle valid pulse and no ready. The consumer has to take it in that cycle, since the link cannot be slowed. Transmit and receive halves share only clock and reset, so they can sit on two devices or be looped back.

Top module: `strip_link`

## Requirements
- R1: Bit c of the sent vector is the OR of hit_rows bits r*16+c for rows r = 0, 1, 2.
- R2: The k-th beat of a frame (k = 0..3) carries vector bits 4k+3..4k on tx_lanes[3:0], in consecutive cycles.
- R3: tx_strobe rises in the cycle that carries beat 0 of the first frame and stays high while shutter stays high.
- R4: In the cycle after a clock edge that sees shutter low, tx_lanes is 0 and tx_strobe is 0, whatever hit_valid does.
- R5: hit_ready is high only when shutter is high and the transmitter is idle or at a frame boundary; a vector accepted at an edge puts beat 0 on the lanes in the next cycle.
- R6: When the link is running and hit_valid is low at a frame boundary, a frame of four all-zero beats is sent with tx_strobe still high.
- R7: The receiver treats the rx_lanes value present in the cycle of a rx_strobe rising edge as bits 3..0 of a new vector.
- R8: vec_valid is high for exactly the one cycle after the fourth beat is present, with vec_data holding the four beats in order.
- R9: rx_strobe low drops any partly received vector and the lock, and vec_valid stays low until four beats after the next rising edge.
- R10: Once locked, the receiver counts beats modulo 4 for as long as rx_strobe stays high, giving one vector every four cycles.
- R11: After reset, tx_lanes, tx_strobe and vec_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (beat rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutter | input | 1 | Acquisition window; high enables transmission |
| hit_valid | input | 1 | Hit matrix on hit_rows is offered |
| hit_ready | output | 1 | Transmitter takes the matrix at this edge |
| hit_rows | input | 48 | Pixel hits, row-major: bit r*16+c is row r, column c |
| tx_lanes | output | 4 | Serial strip lanes, one beat per cycle |
| tx_strobe | output | 1 | Frame strobe, rises with the first beat |
| rx_lanes | input | 4 | Received strip lanes |
| rx_strobe | input | 1 | Received frame strobe |
| vec_valid | output | 1 | One-cycle pulse: vec_data holds a full vector |
| vec_data | output | 16 | Rebuilt column hit vector |

## Verification
Two events can fall on the same edge. A frame boundary of the transmitter can coincide with the shutter closing, and the last beat of a frame at the receiver can coincide with the strobe falling or with a new frame starting. The random run closes the window at arbitrary beats and withholds hit_valid at random boundaries, while a directed sequence drives the receive lanes by hand so that the strobe drops in the middle of a frame and then rises again. Every cycle is compared with a bench model built from the requirements: the lane contents, the strobe, ready and the rebuilt vector must match it, and no vector may appear from a frame that was cut short.

// File: rtl/strip_link_pkg.sv
package strip_link_pkg;
  localparam int ROWS_DEF  = 3;
  localparam int COLS_DEF  = 16;
  localparam int LANES_DEF = 4;

  // Width of a counter that indexes beats within one frame.
  function automatic int beat_bits(input int beats);
    return (beats > 1) ? $clog2(beats) : 1;
  endfunction
endpackage

// File: rtl/strip_col_or.sv
module strip_col_or #(
  parameter int ROWS = strip_link_pkg::ROWS_DEF,
  parameter int COLS = strip_link_pkg::COLS_DEF
) (
  input  logic [ROWS*COLS-1:0] hits,
  output logic [COLS-1:0]      cols
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic any;
    always_comb begin
      any = 1'b0;
      for (int r = 0; r < ROWS; r++) any = any | hits[r*COLS + c];
    end
    assign cols[c] = any;
  end
endmodule

// File: rtl/strip_tx_ser.sv
module strip_tx_ser #(
  parameter int COLS  = strip_link_pkg::COLS_DEF,
  parameter int LANES = strip_link_pkg::LANES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shutter,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [COLS-1:0]  in_vec,
  output logic [LANES-1:0] lanes,
  output logic             strobe
);
  localparam int BEATS = COLS / LANES;
  localparam int BW    = strip_link_pkg::beat_bits(BEATS);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic            running;
  logic [BW-1:0]   beat;
  logic [COLS-1:0] shift;
  logic            boundary, accept;
  logic [COLS-1:0] frame;

  assign boundary = !running || (beat == '0);
  assign in_ready = shutter && boundary;
  assign accept   = in_valid && in_ready;
  assign frame    = accept ? in_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      beat    <= '0;
      shift   <= '0;
      lanes   <= '0;
      strobe  <= 1'b0;
    end else if (!shutter) begin
      running <= 1'b0;
      beat    <= '0;
      shift   <= '0;
      lanes   <= '0;
      strobe  <= 1'b0;
    end else if (boundary) begin
      if (accept || running) begin
        running <= 1'b1;
        strobe  <= 1'b1;
        lanes   <= frame[LANES-1:0];
        shift   <= frame >> LANES;
        beat    <= (BEATS > 1) ? BW'(1) : '0;
      end
    end else begin
      lanes <= shift[LANES-1:0];
      shift <= shift >> LANES;
      beat  <= (beat == LAST) ? '0 : beat + BW'(1);
    end
  end
endmodule

// File: rtl/strip_rx_deser.sv
module strip_rx_deser #(
  parameter int COLS  = strip_link_pkg::COLS_DEF,
  parameter int LANES = strip_link_pkg::LANES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lanes,
  input  logic             strobe,
  output logic             out_valid,
  output logic [COLS-1:0]  out_vec
);
  localparam int BEATS = COLS / LANES;
  localparam int BW    = strip_link_pkg::beat_bits(BEATS);
  localparam int AW    = (BEATS > 1) ? (BEATS - 1) * LANES : LANES;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic          strobe_d, locked;
  logic [BW-1:0] cnt, beat_now;
  logic [AW-1:0] acc, acc_nxt;
  logic          start, take, last;

  assign start    = strobe && !strobe_d && !locked;
  assign take     = strobe && (start || locked);
  assign beat_now = start ? '0 : cnt;
  assign last     = take && (beat_now == LAST);

  always_comb begin
    acc_nxt = acc;
    for (int i = 0; i < BEATS - 1; i++)
      if (beat_now == BW'(i)) acc_nxt[i*LANES +: LANES] = lanes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d  <= 1'b0;
      locked    <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      strobe_d  <= strobe;
      out_valid <= 1'b0;
      if (!strobe) begin
        locked <= 1'b0;
        cnt    <= '0;
      end else if (take) begin
        locked <= 1'b1;
        if (last) begin
          out_valid <= 1'b1;
          if (BEATS > 1) out_vec <= COLS'({lanes, acc_nxt[AW-1:0]});
          else           out_vec <= COLS'(lanes);
          cnt <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= beat_now + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/strip_link.sv
module strip_link #(
  parameter int ROWS  = strip_link_pkg::ROWS_DEF,
  parameter int COLS  = strip_link_pkg::COLS_DEF,
  parameter int LANES = strip_link_pkg::LANES_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shutter,
  input  logic                 hit_valid,
  output logic                 hit_ready,
  input  logic [ROWS*COLS-1:0] hit_rows,
  output logic [LANES-1:0]     tx_lanes,
  output logic                 tx_strobe,
  input  logic [LANES-1:0]     rx_lanes,
  input  logic                 rx_strobe,
  output logic                 vec_valid,
  output logic [COLS-1:0]      vec_data
);
  logic [COLS-1:0] col_vec;

  strip_col_or #(.ROWS(ROWS), .COLS(COLS)) u_or (
    .hits (hit_rows),
    .cols (col_vec)
  );

  strip_tx_ser #(.COLS(COLS), .LANES(LANES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shutter  (shutter),
    .in_valid (hit_valid),
    .in_ready (hit_ready),
    .in_vec   (col_vec),
    .lanes    (tx_lanes),
    .strobe   (tx_strobe)
  );

  strip_rx_deser #(.COLS(COLS), .LANES(LANES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .lanes     (rx_lanes),
    .strobe    (rx_strobe),
    .out_valid (vec_valid),
    .out_vec   (vec_data)
  );
endmodule

// File: rtl/strip_link_chk.sv
module strip_link_chk (
  input logic clk,
  input logic rst_n,
  input logic shutter,
  input logic hit_valid,
  input logic hit_ready,
  input logic tx_strobe,
  input logic tx_lane_any,
  input logic rx_strobe,
  input logic vec_valid
);
  // R4
  shutter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter |=> (!tx_strobe && !tx_lane_any));

  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter |-> !hit_ready);

  // R5
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> tx_strobe);

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe && shutter) |=> tx_strobe);

  // R10
  vec_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  // R9
  drop_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |=> !vec_valid);
endmodule

bind strip_link strip_link_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shutter     (shutter),
  .hit_valid   (hit_valid),
  .hit_ready   (hit_ready),
  .tx_strobe   (tx_strobe),
  .tx_lane_any (|tx_lanes),
  .rx_strobe   (rx_strobe),
  .vec_valid   (vec_valid)
);

// File: tb/strip_link_test.sv
module strip_link_test;
  localparam int ROWS = 3, COLS = 16, LANES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 shutter = 1'b0, hit_valid = 1'b0;
  logic [ROWS*COLS-1:0] hit_rows = '0;
  logic                 hit_ready;
  logic [LANES-1:0]     tx_lanes;
  logic                 tx_strobe;
  logic                 direct = 1'b0;
  logic [LANES-1:0]     d_lanes = '0;
  logic                 d_strobe = 1'b0;
  logic [LANES-1:0]     rx_lanes;
  logic                 rx_strobe;
  logic                 vec_valid;
  logic [COLS-1:0]      vec_data;

  assign rx_lanes  = direct ? d_lanes  : tx_lanes;
  assign rx_strobe = direct ? d_strobe : tx_strobe;

  strip_link uut (
    .clk(clk), .rst_n(rst_n), .shutter(shutter), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_rows(hit_rows), .tx_lanes(tx_lanes),
    .tx_strobe(tx_strobe), .rx_lanes(rx_lanes), .rx_strobe(rx_strobe),
    .vec_valid(vec_valid), .vec_data(vec_data)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] fold(input logic [ROWS*COLS-1:0] h);
    logic [COLS-1:0] v = '0;
    for (int r = 0; r < ROWS; r++) v |= h[r*COLS +: COLS];
    return v;
  endfunction

  // reference state, from the requirements
  logic [3:0]  exp_lanes = '0;
  logic        exp_strobe = 1'b0;
  bit          started = 0;
  int          left = 0;
  logic [15:0] rem = '0;
  bit          m_prev = 0, m_lock = 0;
  int          m_cnt = 0;
  logic [15:0] m_acc = '0;
  logic        exp_vv = 1'b0;
  logic [15:0] exp_vd = '0;
  logic        obs_vv, obs_strobe;
  logic [3:0]  obs_lanes;
  logic [15:0] obs_vd;

  task automatic step(input logic sh, input logic v, input logic [ROWS*COLS-1:0] rows,
                      input logic dir, input logic [3:0] dl, input logic ds);
    logic [15:0] fr;
    bit er;
    @(negedge clk);
    obs_vv = vec_valid; obs_vd = vec_data;
    obs_lanes = tx_lanes; obs_strobe = tx_strobe;
    check(tx_lanes == exp_lanes, "R2 lane beat", 32'(tx_lanes), 32'(exp_lanes));
    check(tx_strobe == exp_strobe, "R3 strobe", 32'(tx_strobe), 32'(exp_strobe));
    check(vec_valid == exp_vv, "R8 vec_valid", 32'(vec_valid), 32'(exp_vv));
    if (exp_vv) check(vec_data == exp_vd, "R7 vec_data", 32'(vec_data), 32'(exp_vd));
    shutter = sh; hit_valid = v; hit_rows = rows;
    direct = dir; d_lanes = dl; d_strobe = ds;
    #1;
    er = sh && (!started || left == 0);
    check(hit_ready == er, "R5 hit_ready", 32'(hit_ready), 32'(er));
    // transmitter model
    if (!sh) begin
      exp_lanes = '0; exp_strobe = 1'b0; started = 0; left = 0;
    end else if (er) begin
      if (v) begin fr = fold(rows); started = 1; end
      else fr = '0;
      if (started) begin
        exp_lanes = fr[3:0]; rem = fr >> 4; left = 3; exp_strobe = 1'b1;
      end else begin
        exp_lanes = '0; exp_strobe = 1'b0;
      end
    end else begin
      exp_lanes = rem[3:0]; rem = rem >> 4; left--; exp_strobe = 1'b1;
    end
    // receiver model on the current receive inputs
    exp_vv = 1'b0;
    if (!rx_strobe) begin
      m_lock = 0; m_cnt = 0;
    end else if (m_lock || !m_prev) begin
      if (!m_lock) m_cnt = 0;
      m_acc[m_cnt*4 +: 4] = rx_lanes;
      m_lock = 1;
      if (m_cnt == 3) begin exp_vv = 1'b1; exp_vd = m_acc; m_cnt = 0; end
      else m_cnt++;
    end
    m_prev = rx_strobe;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int valids;
    logic sh;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_lanes == 0 && !tx_strobe && !vec_valid, "R11 reset state",
          {tx_lanes, tx_strobe, vec_valid}, 32'h0);

    // R4: window closed, producer valid: nothing leaves
    step(0, 1, '1, 0, 0, 0);
    step(0, 1, '1, 0, 0, 0);
    check(obs_lanes == 0 && !obs_strobe, "R4 closed window", {obs_lanes, obs_strobe}, 32'h0);

    // R1: row-spread hits, then idle boundaries
    step(1, 1, (48'h1 << (2*16 + 5)) | (48'h1 << 12) | (48'h1 << (16 + 12)), 0, 0, 0);
    step(1, 0, '0, 0, 0, 0);
    check(obs_strobe && obs_lanes == 4'h0, "R3 first beat with strobe", {obs_lanes, obs_strobe}, 32'h1);
    for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 0, 0);
    check(obs_vv && obs_vd == 16'h1020, "R1 column fold", 32'(obs_vd), 32'h1020);
    for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 0, 0);
    check(obs_vv && obs_vd == 16'h0000 && obs_strobe, "R6 zero frame", {obs_vv, obs_vd}, 32'h10000);
    step(0, 0, '0, 0, 0, 0);
    step(0, 0, '0, 0, 0, 0);
    check(obs_lanes == 0 && !obs_strobe, "R4 after close", {obs_lanes, obs_strobe}, 32'h0);

    // R9 / R10: hand-driven receive lanes
    step(0, 0, '0, 1, 4'h3, 1);
    step(0, 0, '0, 1, 4'h5, 1);
    step(0, 0, '0, 1, 4'h6, 0);
    step(0, 0, '0, 1, 4'h7, 0);
    for (int i = 0; i < 4; i++) step(0, 0, '0, 1, 4'h0, 0);
    check(!obs_vv, "R9 cut frame dropped", 32'(obs_vv), 32'h0);
    valids = 0;
    for (int i = 0; i < 12; i++) begin
      step(0, 0, '0, 1, 4'(i + 1), 1);
      if (obs_vv) valids++;
    end
    step(0, 0, '0, 1, 4'h0, 1);
    if (obs_vv) valids++;
    check(valids == 3, "R10 continuous frames", 32'(valids), 32'd3);
    step(0, 0, '0, 1, 4'h0, 0);
    step(0, 0, '0, 0, 4'h0, 0);

    // random traffic in loopback
    sh = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      logic [ROWS*COLS-1:0] h;
      if ($urandom_range(39) == 0) sh = ~sh;
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      step(sh, ($urandom_range(3) != 0), h, 0, 0, 0);
    end
    for (int i = 0; i < 8; i++) step(0, 0, '0, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule